// File: doc/BRIEF.md
# Operand-Gathering Computation Unit Controller

This block supervises one operation between an issue stage and a functional unit, from the moment the operation is dispatched until its result is stored. A dispatch pulse latches the operation fields and a per-port skip mask. The controller then fetches each source operand through its own request/acknowledge pair, starts the built-in functional unit once every required operand is in hand, and presents the result on a write-back request/acknowledge pair. The occupied flag covers the whole span, from the cycle after dispatch to the cycle after the write-back acknowledge.

A source port is skipped, and never asks for data, when its skip-mask bit is set, when port 0 is forced to zero, or when port 1 takes the immediate value instead. Some operations finish in the same cycle their operands arrive. Others take a fixed number of cycles set by a parameter. In both cases the result is held until the write-back slot is granted.

Top module: `opg_cu_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves occupied_o, every opnd_req_o bit and wb_req_o low, and they stay low while the unit is idle.
- R2: occupied_o is low in the cycle in which a dispatch is first sampled and high from the next cycle on. It never rises without a dispatch. A dispatch presented while occupied_o is high is ignored: it starts no second operation and adds no result.
- R3: Each required source port raises its opnd_req_o bit in the cycle after dispatch and holds it through any number of stall cycles until its opnd_ack_i bit is seen.
- R4: An opnd_req_o bit falls in the cycle after its acknowledge, and it is not raised again during the same operation. The operand is taken from opnd_data_i in the acknowledge cycle, and later changes on that input have no effect.
- R5: A port never raises its request when its skip_mask_i bit is set, when it is port 0 with op_clr_a_i set, or when it is port 1 with op_use_imm_i set. A masked port supplies 0, a cleared port 0 supplies 0, and port 1 with the immediate flag supplies op_imm_i.
- R6: Result encoding on op_code_i, modulo 2^W, where A is port 0 after clearing and then, if op_neg_a_i, a bitwise inversion: 0 gives A+B+C (takes ADD_LAT cycles), 1 gives A-B (same cycle), 2 gives A (same cycle), 3 gives the low W bits of A*B (takes MUL_LAT cycles). C is port 2, or 0 with only two ports.
- R7: The functional unit is started only after every required port has been read, so wb_req_o is never high while any opnd_req_o bit is high.
- R8: When the result is ready, wb_req_o rises and wb_data_o carries the result. Both stay unchanged until wb_ack_i is seen. A result produced in the same cycle as the operands is not lost.
- R9: In the cycle after wb_ack_i is seen with wb_req_o high, both wb_req_o and occupied_o are low. With no stalls, a whole operation completes in well under 50 cycles.
- R10: The operation fields and the skip mask are captured in the dispatch cycle. Changing them afterwards does not alter the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dispatch_i | input | 1 | Dispatch pulse that starts an operation |
| op_code_i | input | 2 | Operation select (see R6) |
| op_neg_a_i | input | 1 | Invert port 0 operand bitwise |
| op_clr_a_i | input | 1 | Force port 0 operand to zero, skip its read |
| op_use_imm_i | input | 1 | Use immediate for port 1, skip its read |
| op_imm_i | input | W | Immediate value |
| skip_mask_i | input | NSRC | Per-port read suppression |
| occupied_o | output | 1 | Unit holds an operation |
| opnd_req_o | output | NSRC | Per-port operand request |
| opnd_ack_i | input | NSRC | Per-port operand acknowledge |
| opnd_data_i | input | NSRC*W | Operand data, port i at bits i*W upward |
| wb_req_o | output | 1 | Result write-back request |
| wb_ack_i | input | 1 | Result write-back acknowledge |
| wb_data_o | output | W | Result value |

## Verification
The bench stalls each port's acknowledge by a different number of cycles. A design that dropped a request early or raised it again would show a request low during a stall or high after its acknowledge. It runs same-cycle operations, which a design that lost the combinational result would hang on or answer with stale data, and it holds off the write-back acknowledge to catch a result that changes or a request that drops before the grant. It skips ports by mask, by zero-forcing and by immediate, where a wrong design would raise a request or use the wrong operand. It also pulses dispatch mid-operation and changes the fields after dispatch, which a design with a leaky latch or issue gate would answer with a second result or a corrupted one.

// File: rtl/opg_pkg.sv
package opg_pkg;

  typedef enum logic [1:0] {
    OPC_ADD  = 2'd0,
    OPC_SUB  = 2'd1,
    OPC_PASS = 2'd2,
    OPC_MUL  = 2'd3
  } opc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATHER,
    ST_EXEC,
    ST_WB
  } cu_state_e;

  // operations answered in the same cycle the operands arrive
  function automatic logic is_instant(opc_e o);
    return (o == OPC_SUB) || (o == OPC_PASS);
  endfunction

  // port index p must be fetched unless masked or supplied internally
  function automatic logic port_needed(int p, logic masked, logic clr_a, logic use_imm);
    logic internal;
    internal = ((p == 0) && clr_a) || ((p == 1) && use_imm);
    return !masked && !internal;
  endfunction

endpackage

// File: rtl/opg_src_port.sv
module opg_src_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         need,
  input  logic         ack,
  input  logic [W-1:0] din,
  output logic         req,
  output logic         got,
  output logic [W-1:0] val
);

  logic take;
  assign take = req && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      got <= 1'b0;
      val <= '0;
    end else if (arm) begin
      req <= need;
      got <= !need;
      val <= '0;
    end else if (take) begin
      req <= 1'b0;
      got <= 1'b1;
      val <= din;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !arm) |=> req);

  p_req_origin_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(arm && need));

  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> (!req && got && val == $past(din)));

  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (arm && !need) |=> !req);

endmodule

// File: rtl/opg_fu.sv
module opg_fu
  import opg_pkg::*;
#(
  parameter int W       = 16,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  opc_e         opc,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         done,
  output logic [W-1:0] res
);

  localparam int MAXL = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
  localparam int CW   = $clog2(MAXL + 1);

  function automatic logic [W-1:0] calc(opc_e o, logic [W-1:0] x,
                                        logic [W-1:0] y, logic [W-1:0] z);
    logic [2*W-1:0] prod;
    prod = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    case (o)
      OPC_ADD:  return x + y + z;
      OPC_SUB:  return x - y;
      OPC_PASS: return x;
      default:  return prod[W-1:0];
    endcase
  endfunction

  function automatic logic [CW-1:0] wait_of(opc_e o);
    return (o == OPC_ADD) ? CW'(ADD_LAT - 1) : CW'(MUL_LAT - 1);
  endfunction

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  res_q;
  logic          instant;
  logic          fast_done;
  logic          slow_done;

  assign instant   = is_instant(opc);
  assign fast_done = start && instant;
  assign slow_done = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      res_q <= '0;
    end else if (start && !instant) begin
      run   <= 1'b1;
      cnt   <= wait_of(opc);
      res_q <= calc(opc, a, b, c);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign done = fast_done || slow_done;
  assign res  = fast_done ? calc(opc, a, b, c) : res_q;

  p_fu_start_free_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !run);

  p_fu_finish_r8: assert property (@(posedge clk) disable iff (rst)
    slow_done |=> !run);

endmodule

// File: rtl/opg_wb.sv
module opg_wb #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ack,
  output logic         req,
  output logic [W-1:0] data,
  output logic         fin
);

  assign fin = req && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      data <= '0;
    end else if (load) begin
      req  <= 1'b1;
      data <= din;
    end else if (fin) begin
      req <= 1'b0;
    end
  end

  p_wb_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (req && data == $past(din)));

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(data)));

  p_wb_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);

endmodule

// File: rtl/opg_cu_ctrl.sv
module opg_cu_ctrl
  import opg_pkg::*;
#(
  parameter int W       = 16,
  parameter int NSRC    = 3,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dispatch_i,
  input  logic [1:0]        op_code_i,
  input  logic              op_neg_a_i,
  input  logic              op_clr_a_i,
  input  logic              op_use_imm_i,
  input  logic [W-1:0]      op_imm_i,
  input  logic [NSRC-1:0]   skip_mask_i,
  output logic              occupied_o,
  output logic [NSRC-1:0]   opnd_req_o,
  input  logic [NSRC-1:0]   opnd_ack_i,
  input  logic [NSRC*W-1:0] opnd_data_i,
  output logic              wb_req_o,
  input  logic              wb_ack_i,
  output logic [W-1:0]      wb_data_o
);

  // operand 0 after optional clear and inversion
  function automatic logic [W-1:0] shape_a(logic [W-1:0] v, logic clr, logic neg);
    logic [W-1:0] x;
    x = clr ? '0 : v;
    return neg ? ~x : x;
  endfunction

  cu_state_e    state_q;
  opc_e         opc_q;
  logic         neg_q;
  logic         clr_q;
  logic         imm_use_q;
  logic [W-1:0] imm_q;

  // named internal events
  logic ev_accept;
  logic ev_all_got;
  logic ev_fu_start;
  logic ev_fu_done;
  logic ev_wb_fin;

  logic [NSRC-1:0] need;
  logic [NSRC-1:0] got;
  logic [W-1:0]    port_val [NSRC];

  logic [W-1:0] fu_a;
  logic [W-1:0] fu_b;
  logic [W-1:0] fu_c;
  logic [W-1:0] fu_res;

  assign ev_accept   = (state_q == ST_IDLE) && dispatch_i;
  assign ev_all_got  = &got;
  assign ev_fu_start = (state_q == ST_GATHER) && ev_all_got;

  for (genvar p = 0; p < NSRC; p++) begin : g_port
    assign need[p] = port_needed(p, skip_mask_i[p], op_clr_a_i, op_use_imm_i);

    opg_src_port #(.W(W)) u_port (
      .clk  (clk),
      .rst  (rst),
      .arm  (ev_accept),
      .need (need[p]),
      .ack  (opnd_ack_i[p]),
      .din  (opnd_data_i[p*W +: W]),
      .req  (opnd_req_o[p]),
      .got  (got[p]),
      .val  (port_val[p])
    );
  end

  assign fu_a = shape_a(port_val[0], clr_q, neg_q);
  assign fu_b = imm_use_q ? imm_q : port_val[1];

  if (NSRC > 2) begin : g_third
    assign fu_c = port_val[2];
  end else begin : g_no_third
    assign fu_c = '0;
  end

  opg_fu #(.W(W), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_fu (
    .clk   (clk),
    .rst   (rst),
    .start (ev_fu_start),
    .opc   (opc_q),
    .a     (fu_a),
    .b     (fu_b),
    .c     (fu_c),
    .done  (ev_fu_done),
    .res   (fu_res)
  );

  opg_wb #(.W(W)) u_wb (
    .clk  (clk),
    .rst  (rst),
    .load (ev_fu_done),
    .din  (fu_res),
    .ack  (wb_ack_i),
    .req  (wb_req_o),
    .data (wb_data_o),
    .fin  (ev_wb_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      opc_q     <= OPC_ADD;
      neg_q     <= 1'b0;
      clr_q     <= 1'b0;
      imm_use_q <= 1'b0;
      imm_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          state_q   <= ST_GATHER;
          opc_q     <= opc_e'(op_code_i);
          neg_q     <= op_neg_a_i;
          clr_q     <= op_clr_a_i;
          imm_use_q <= op_use_imm_i;
          imm_q     <= op_imm_i;
        end
        ST_GATHER: if (ev_fu_start) begin
          state_q <= ev_fu_done ? ST_WB : ST_EXEC;
        end
        ST_EXEC: if (ev_fu_done) begin
          state_q <= ST_WB;
        end
        default: if (ev_wb_fin) begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign occupied_o = (state_q != ST_IDLE);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !occupied_o |-> (opnd_req_o == '0 && !wb_req_o));

  p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(occupied_o) |-> $past(dispatch_i));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (!occupied_o && dispatch_i) |=> occupied_o);

  p_wb_gated_r7: assert property (@(posedge clk) disable iff (rst)
    wb_req_o |-> (opnd_req_o == '0));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (occupied_o && !(wb_req_o && wb_ack_i)) |=> occupied_o);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_req_o && wb_ack_i) |=> (!occupied_o && !wb_req_o));

endmodule

// File: tb/opg_cu_ctrl_bench.sv
`timescale 1ns/1ps
module opg_cu_ctrl_bench;

  localparam int W    = 16;
  localparam int NSRC = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              dispatch_i;
  logic [1:0]        op_code_i;
  logic              op_neg_a_i;
  logic              op_clr_a_i;
  logic              op_use_imm_i;
  logic [W-1:0]      op_imm_i;
  logic [NSRC-1:0]   skip_mask_i;
  logic              occupied_o;
  logic [NSRC-1:0]   opnd_req_o;
  logic [NSRC-1:0]   opnd_ack_i;
  logic [NSRC*W-1:0] opnd_data_i;
  logic              wb_req_o;
  logic              wb_ack_i;
  logic [W-1:0]      wb_data_o;

  always #5 clk = ~clk;

  opg_cu_ctrl #(.W(W), .NSRC(NSRC)) u_opg_cu_ctrl (
    .clk(clk), .rst(rst), .dispatch_i(dispatch_i), .op_code_i(op_code_i),
    .op_neg_a_i(op_neg_a_i), .op_clr_a_i(op_clr_a_i), .op_use_imm_i(op_use_imm_i),
    .op_imm_i(op_imm_i), .skip_mask_i(skip_mask_i), .occupied_o(occupied_o),
    .opnd_req_o(opnd_req_o), .opnd_ack_i(opnd_ack_i), .opnd_data_i(opnd_data_i),
    .wb_req_o(wb_req_o), .wb_ack_i(wb_ack_i), .wb_data_o(wb_data_o)
  );

  int checks = 0;
  int errors = 0;
  int wb_stall = 0;
  logic [W-1:0] exp_q[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference result written from the requirement text (R5, R6)
  function automatic logic [W-1:0] model(int opc, bit neg, bit clr, bit ui,
      logic [W-1:0] imm, logic [NSRC-1:0] m, logic [W-1:0] a, logic [W-1:0] b,
      logic [W-1:0] c);
    int unsigned lim, x, y, z, r;
    lim = (32'd1 << W) - 1;
    x = (clr || m[0]) ? 0 : 32'(a);
    if (neg) x = (~x) & lim;
    y = ui ? 32'(imm) : (m[1] ? 0 : 32'(b));
    z = m[2] ? 0 : 32'(c);
    if (opc == 0)      r = x + y + z;
    else if (opc == 1) r = x - y;
    else if (opc == 2) r = x;
    else               r = x * y;
    return W'(r & lim);
  endfunction

  // monitor: pops the scoreboard and grants write-back
  initial begin : monitor
    int stall_cnt;
    logic [W-1:0] held;
    logic [W-1:0] want;
    stall_cnt = 0;
    held = '0;
    wb_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (wb_ack_i) begin
        wb_ack_i = 1'b0;
        check(!wb_req_o, "R9", "wb request after ack", int'(wb_req_o), 0);
        check(!occupied_o, "R9", "occupied after ack", int'(occupied_o), 0);
        stall_cnt = 0;
      end else if (wb_req_o) begin
        check(opnd_req_o == '0, "R7", "operand request during write-back",
              int'(opnd_req_o), 0);
        if (stall_cnt == 0) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected extra result", int'(wb_data_o), -1);
          end else begin
            want = exp_q.pop_front();
            check(wb_data_o == want, "R6", "result value", int'(wb_data_o), int'(want));
          end
          held = wb_data_o;
        end else begin
          check(wb_data_o == held, "R8", "result stable while stalled",
                int'(wb_data_o), int'(held));
        end
        if (stall_cnt == wb_stall) wb_ack_i = 1'b1;
        else stall_cnt++;
      end
    end
  end

  // driver: pushes expectation, dispatches, serves operand handshakes
  task automatic run_op(int opc, bit neg, bit clr, bit ui, logic [W-1:0] imm,
      logic [NSRC-1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
      int d0, int d1, int d2, bit poke);
    logic [W-1:0] vals [NSRC];
    int dly [NSRC];
    bit need [NSRC];
    int st [NSRC];
    int cnt [NSRC];
    int cyc;
    vals[0] = a; vals[1] = b; vals[2] = c;
    dly[0] = d0; dly[1] = d1; dly[2] = d2;
    exp_q.push_back(model(opc, neg, clr, ui, imm, m, a, b, c));
    repeat (2) begin
      @(negedge clk);
      check(!occupied_o, "R2", "occupied rose with no dispatch", int'(occupied_o), 0);
    end
    dispatch_i   = 1'b1;
    op_code_i    = 2'(opc);
    op_neg_a_i   = neg;
    op_clr_a_i   = clr;
    op_use_imm_i = ui;
    op_imm_i     = imm;
    skip_mask_i  = m;
    check(!occupied_o, "R2", "occupied in dispatch cycle", int'(occupied_o), 0);
    @(negedge clk);
    dispatch_i = 1'b0;
    // R10: scramble the fields after the dispatch cycle
    op_code_i    = ~2'(opc);
    op_neg_a_i   = !neg;
    op_clr_a_i   = !clr;
    op_use_imm_i = !ui;
    op_imm_i     = ~imm;
    skip_mask_i  = ~m;
    check(occupied_o, "R2", "occupied after dispatch", int'(occupied_o), 1);
    for (int i = 0; i < NSRC; i++) begin
      need[i] = !m[i] && !(i == 0 && clr) && !(i == 1 && ui);
      st[i] = 0;
      cnt[i] = 0;
    end
    cyc = 0;
    while (occupied_o && cyc < 50) begin
      for (int i = 0; i < NSRC; i++) begin
        if (!need[i]) begin
          check(!opnd_req_o[i], "R5", "skipped port requested", int'(opnd_req_o[i]), 0);
        end else if (st[i] == 0) begin
          check(opnd_req_o[i], "R3", "request held until ack", int'(opnd_req_o[i]), 1);
          if (cnt[i] == dly[i]) begin
            opnd_ack_i[i] = 1'b1;
            opnd_data_i[i*W +: W] = vals[i];
            st[i] = 1;
          end else begin
            cnt[i]++;
          end
        end else if (st[i] == 1) begin
          opnd_ack_i[i] = 1'b0;
          opnd_data_i[i*W +: W] = 16'hDEAD;
          check(!opnd_req_o[i], "R4", "request after ack", int'(opnd_req_o[i]), 0);
          st[i] = 2;
        end else begin
          check(!opnd_req_o[i], "R4", "request raised again", int'(opnd_req_o[i]), 0);
        end
      end
      dispatch_i = poke && (cyc == 1);
      @(negedge clk);
      cyc++;
    end
    dispatch_i = 1'b0;
    opnd_ack_i = '0;
    check(!occupied_o, "R9", "operation finished within 50 cycles", cyc, 50);
    for (int i = 0; i < NSRC; i++) begin
      if (need[i]) check(st[i] == 2, "R7", "port read before completion", st[i], 2);
    end
    if (poke) begin
      @(negedge clk);
      check(!occupied_o, "R2", "dispatch while occupied started work",
            int'(occupied_o), 0);
      check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    rst = 1'b1;
    dispatch_i = 1'b0;
    op_code_i = '0;
    op_neg_a_i = 1'b0;
    op_clr_a_i = 1'b0;
    op_use_imm_i = 1'b0;
    op_imm_i = '0;
    skip_mask_i = '0;
    opnd_ack_i = '0;
    opnd_data_i = '0;
    repeat (3) @(negedge clk);
    check(!occupied_o, "R1", "occupied in reset", int'(occupied_o), 0);
    check(opnd_req_o == '0, "R1", "operand requests in reset", int'(opnd_req_o), 0);
    check(!wb_req_o, "R1", "wb request in reset", int'(wb_req_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!occupied_o && opnd_req_o == '0 && !wb_req_o, "R1", "idle after reset",
          int'(occupied_o), 0);

    wb_stall = 0;
    // R6 add, no stalls: 5+2+1
    run_op(0, 0, 0, 0, 16'd0, 3'b000, 16'd5, 16'd2, 16'd1, 0, 0, 0, 0);
    // R3 R4 staggered operand stalls: 100+23+7
    run_op(0, 0, 0, 0, 16'd0, 3'b000, 16'd100, 16'd23, 16'd7, 0, 3, 1, 0);
    // R8 same-cycle subtract, port 2 masked: 5-2
    run_op(1, 0, 0, 0, 16'd0, 3'b100, 16'd5, 16'd2, 16'd9, 1, 0, 0, 0);
    // R6 inverted port 0: ~5+2+0
    run_op(0, 1, 0, 0, 16'd0, 3'b000, 16'd5, 16'd2, 16'd0, 0, 0, 2, 0);
    // R5 cleared port 0 and immediate port 1: 0+7+4
    run_op(0, 0, 1, 1, 16'd7, 3'b000, 16'd50, 16'd60, 16'd4, 0, 0, 2, 0);
    // R5 every port masked: pass gives 0
    run_op(2, 0, 0, 0, 16'd0, 3'b111, 16'd99, 16'd98, 16'd97, 0, 0, 0, 0);
    // R8 multiply with write-back stalled four cycles: 300*3
    wb_stall = 4;
    run_op(3, 0, 0, 0, 16'd0, 3'b100, 16'd300, 16'd3, 16'd0, 2, 1, 0, 0);
    wb_stall = 0;
    // R2 dispatch while occupied is ignored: 40-50 wraps
    run_op(1, 0, 0, 0, 16'd0, 3'b100, 16'd40, 16'd50, 16'd0, 2, 2, 0, 1);
    // R10 pass with inversion, fields scrambled after dispatch
    wb_stall = 1;
    run_op(2, 1, 0, 0, 16'd0, 3'b110, 16'h00FF, 16'd1, 16'd1, 2, 0, 0, 0);
    wb_stall = 0;
    // R5 masked port 1 without immediate contributes 0: 9+0+3
    run_op(0, 0, 0, 0, 16'd0, 3'b010, 16'd9, 16'd77, 16'd3, 1, 0, 0, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "all results delivered", exp_q.size(), 0);
    check(!occupied_o && !wb_req_o, "R9", "idle at end", int'(occupied_o), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule